// File: doc/BRIEF.md
# Streaming Integer Matrix Multiply Engine

This block multiplies two square integer matrices of parameterised dimension and exchanges all data over streaming handshakes. A one-cycle start pulse begins a run. The engine then takes both operands, one after the other, from a single input stream. Next it forms every product element in a sequential multiply-accumulate loop. Last, it streams the product matrix out, flagging the final word with a last marker. Start, done, idle and ready lines let a sequencer or a DMA driver launch runs and watch their progress.

Operands and results are 32-bit words. Arithmetic is integer multiply-accumulate that wraps modulo 2^32, so signed two's-complement operands give the low 32 bits of the exact signed result. All three matrices sit in local registers. Loading and unloading move one word per clock while the far side keeps its handshake asserted.

Top module: `matmul_stream`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the block to idle: idleOut is 1 and inReady, outValid, outLast, doneOut and readyOut are 0.
- R2: idleOut is 1 exactly when no run is active. A startIn pulse while a run is active is ignored, and no second run follows.
- R3: inReady is 1 only during the load phase. Input words are taken on cycles where inValid and inReady are both 1. Words with stream index k = 0 .. N*N-1 fill A[k/N][k%N], and words with index N*N + k fill B[k/N][k%N] (row-major order).
- R4: Result element C[i][j] equals the sum over d of A[i][d]*B[d][j], taken modulo 2^32. The accumulator starts from zero for every element and every run.
- R5: Results leave in row-major order, one per cycle with outValid and outReady both 1. outLast is 1 only on the word with index N*N-1.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and outData and outLast hold their values.
- R7: doneOut is a one-cycle pulse in the cycle after the final result is accepted. idleOut returns to 1 in that same cycle.
- R8: readyOut is a one-cycle pulse in the first cycle of the load phase, which is the cycle after startIn is taken while idle.
- R9: With inValid held at 1, the load phase lasts exactly 2*N*N cycles. With outReady held at 1, the N*N results leave on N*N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startIn | input | 1 | Launches a run when sampled high while idle |
| doneOut | output | 1 | One-cycle pulse after the last result is accepted |
| idleOut | output | 1 | High when no run is active |
| readyOut | output | 1 | One-cycle pulse on the first load cycle |
| inData | input | DATA_W (32) | Input stream data: A words, then B words |
| inValid | input | 1 | Input stream valid |
| inReady | output | 1 | Input stream ready; high only while loading |
| outData | output | DATA_W (32) | Result stream data |
| outValid | output | 1 | Result stream valid |
| outReady | input | 1 | Result stream ready |
| outLast | output | 1 | Marks result word N*N-1 |

## Verification
The bench feeds operands that push the accumulator past 2^32, including the most negative value and all-ones words. An engine that saturates, or that leaves the accumulator uncleared between elements or between runs, returns wrong products. Random valid and ready stalls check that only handshaken words count. A design that advances on valid alone fills B with A data or skips results, and one that changes outData under backpressure is caught by the hold check. The bench pulses start during the output phase to catch a restart. It applies reset in the middle of a load. It also counts cycles with the handshakes held open, so a design with a bubble in the load or store phase shows up. The last marker is checked on every word, which catches an off-by-one on the final index.

// File: rtl/matmul_stream_pkg.sv
package matmul_stream_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_CALC  = 2'd2,
    PH_STORE = 2'd3
  } phase_t;

  typedef struct packed {
    logic loadEn;    // write the current input word into operand storage
    logic macEn;     // perform one multiply-accumulate step
    logic macFirst;  // first term of a dot product: start from zero
    logic macLast;   // last term: commit the sum into result storage
  } mmStrobe_t;

endpackage

// File: rtl/matmul_stream_ctrl.sv
module matmul_stream_ctrl
  import matmul_stream_pkg::*;
#(
  parameter int DIM = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             startIn,
  input  logic                             inValid,
  input  logic                             outReady,
  output mmStrobe_t                        strobes,
  output logic [$clog2(2*DIM*DIM)-1:0]     ldIdx,
  output logic [$clog2(DIM)-1:0]           rowI,
  output logic [$clog2(DIM)-1:0]           colJ,
  output logic [$clog2(DIM)-1:0]           dotD,
  output logic [$clog2(DIM*DIM)-1:0]       outIdx,
  output logic                             inReady,
  output logic                             outValid,
  output logic                             outLast,
  output logic                             doneOut,
  output logic                             idleOut,
  output logic                             readyOut
);

  localparam int ELEMS  = DIM * DIM;
  localparam int DIM_W  = $clog2(DIM);
  localparam int ELEM_W = $clog2(ELEMS);
  localparam int LD_W   = $clog2(2 * ELEMS);
  localparam logic [DIM_W-1:0]  DIM_MAX  = DIM_W'(DIM - 1);
  localparam logic [LD_W-1:0]   LD_LAST  = LD_W'(2 * ELEMS - 1);
  localparam logic [ELEM_W-1:0] OUT_LAST = ELEM_W'(ELEMS - 1);

  phase_t phase;
  logic   doneQ;
  logic   readyQ;
  logic   loadHs;
  logic   storeHs;

  assign loadHs  = (phase == PH_LOAD) && inValid;
  assign storeHs = (phase == PH_STORE) && outReady;

  always_comb begin
    strobes          = '0;
    strobes.loadEn   = loadHs;
    strobes.macEn    = (phase == PH_CALC);
    strobes.macFirst = (phase == PH_CALC) && (dotD == '0);
    strobes.macLast  = (phase == PH_CALC) && (dotD == DIM_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      ldIdx  <= '0;
      rowI   <= '0;
      colJ   <= '0;
      dotD   <= '0;
      outIdx <= '0;
      doneQ  <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      doneQ  <= 1'b0;
      readyQ <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (startIn) begin
            phase  <= PH_LOAD;
            readyQ <= 1'b1;
            ldIdx  <= '0;
          end
        end
        PH_LOAD: begin
          if (loadHs) begin
            if (ldIdx == LD_LAST) begin
              phase <= PH_CALC;
              ldIdx <= '0;
              rowI  <= '0;
              colJ  <= '0;
              dotD  <= '0;
            end else begin
              ldIdx <= ldIdx + 1'b1;
            end
          end
        end
        PH_CALC: begin
          if (dotD == DIM_MAX) begin
            dotD <= '0;
            if (colJ == DIM_MAX) begin
              colJ <= '0;
              if (rowI == DIM_MAX) begin
                rowI   <= '0;
                phase  <= PH_STORE;
                outIdx <= '0;
              end else begin
                rowI <= rowI + 1'b1;
              end
            end else begin
              colJ <= colJ + 1'b1;
            end
          end else begin
            dotD <= dotD + 1'b1;
          end
        end
        PH_STORE: begin
          if (storeHs) begin
            if (outIdx == OUT_LAST) begin
              phase  <= PH_IDLE;
              outIdx <= '0;
              doneQ  <= 1'b1;
            end else begin
              outIdx <= outIdx + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign inReady  = (phase == PH_LOAD);
  assign outValid = (phase == PH_STORE);
  assign outLast  = (phase == PH_STORE) && (outIdx == OUT_LAST);
  assign idleOut  = (phase == PH_IDLE);
  assign doneOut  = doneQ;
  assign readyOut = readyQ;

endmodule

// File: rtl/matmul_stream_datapath.sv
module matmul_stream_datapath
  import matmul_stream_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  mmStrobe_t                        strobes,
  input  logic [$clog2(2*DIM*DIM)-1:0]     ldIdx,
  input  logic [$clog2(DIM)-1:0]           rowI,
  input  logic [$clog2(DIM)-1:0]           colJ,
  input  logic [$clog2(DIM)-1:0]           dotD,
  input  logic [$clog2(DIM*DIM)-1:0]       outIdx,
  input  logic [DATA_W-1:0]                inData,
  output logic [DATA_W-1:0]                outData
);

  localparam int ELEMS  = DIM * DIM;
  localparam int ELEM_W = $clog2(ELEMS);
  localparam int LD_W   = $clog2(2 * ELEMS);
  localparam logic [ELEM_W-1:0] DIM_E = ELEM_W'(DIM);

  logic [DATA_W-1:0] aMem [ELEMS];
  logic [DATA_W-1:0] bMem [ELEMS];
  logic [DATA_W-1:0] cMem [ELEMS];
  logic [DATA_W-1:0] acc;

  logic [ELEM_W-1:0] aAddr;
  logic [ELEM_W-1:0] bAddr;
  logic [ELEM_W-1:0] cAddr;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] accNext;

  // Row-major addressing: A walks along a row, B walks down a column.
  assign aAddr = ELEM_W'(rowI) * DIM_E + ELEM_W'(dotD);
  assign bAddr = ELEM_W'(dotD) * DIM_E + ELEM_W'(colJ);
  assign cAddr = ELEM_W'(rowI) * DIM_E + ELEM_W'(colJ);

  // Low half of the product is identical for signed and unsigned operands.
  assign prod    = aMem[aAddr] * bMem[bAddr];
  assign accNext = (strobes.macFirst ? '0 : acc) + prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (strobes.macEn) begin
      acc <= accNext;
    end
  end

  // One register per storage word, each with its own decoded enable.
  for (genvar e = 0; e < ELEMS; e++) begin : g_store
    logic wrA;
    logic wrB;
    logic wrC;
    assign wrA = strobes.loadEn && (ldIdx == LD_W'(e));
    assign wrB = strobes.loadEn && (ldIdx == LD_W'(e + ELEMS));
    assign wrC = strobes.macLast && (cAddr == ELEM_W'(e));

    always_ff @(posedge clk) begin
      if (wrA) aMem[e] <= inData;
      if (wrB) bMem[e] <= inData;
      if (wrC) cMem[e] <= accNext;
    end
  end

  assign outData = cMem[outIdx];

endmodule

// File: rtl/matmul_stream.sv
module matmul_stream
  import matmul_stream_pkg::*;
#(
  parameter int DIM    = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  output logic              doneOut,
  output logic              idleOut,
  output logic              readyOut,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outLast
);

  localparam int ELEMS  = DIM * DIM;
  localparam int DIM_W  = $clog2(DIM);
  localparam int ELEM_W = $clog2(ELEMS);
  localparam int LD_W   = $clog2(2 * ELEMS);

  mmStrobe_t         strobes;
  logic [LD_W-1:0]   ldIdx;
  logic [DIM_W-1:0]  rowI;
  logic [DIM_W-1:0]  colJ;
  logic [DIM_W-1:0]  dotD;
  logic [ELEM_W-1:0] outIdx;

  matmul_stream_ctrl #(.DIM(DIM)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startIn  (startIn),
    .inValid  (inValid),
    .outReady (outReady),
    .strobes  (strobes),
    .ldIdx    (ldIdx),
    .rowI     (rowI),
    .colJ     (colJ),
    .dotD     (dotD),
    .outIdx   (outIdx),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .doneOut  (doneOut),
    .idleOut  (idleOut),
    .readyOut (readyOut)
  );

  matmul_stream_datapath #(.DIM(DIM), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .ldIdx   (ldIdx),
    .rowI    (rowI),
    .colJ    (colJ),
    .dotD    (dotD),
    .outIdx  (outIdx),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/matmul_stream_chk.sv
module matmul_stream_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              startIn,
  input logic              doneOut,
  input logic              idleOut,
  input logic              readyOut,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] outData,
  input logic              outValid,
  input logic              outReady,
  input logic              outLast
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (idleOut && !inReady && !outValid && !doneOut && !readyOut));

  p_idle_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    idleOut |-> (!inReady && !outValid));

  p_start_busy_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (startIn && !idleOut && !outValid) |=> !idleOut);

  p_load_only_r3: assert property (@(posedge clk) disable iff (rst)
    inReady |-> (!outValid && !idleOut));

  p_last_only_valid_r5: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  p_hold_under_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  p_done_follows_last_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady && outLast) |=> (doneOut && idleOut));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);

  p_ready_after_start_r8: assert property (@(posedge clk) disable iff (rst)
    (startIn && idleOut) |=> (readyOut && inReady));

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    readyOut |=> !readyOut);

endmodule

bind matmul_stream matmul_stream_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .startIn  (startIn),
  .doneOut  (doneOut),
  .idleOut  (idleOut),
  .readyOut (readyOut),
  .inValid  (inValid),
  .inReady  (inReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .outLast  (outLast)
);

// File: tb/matmul_stream_tb.sv
module matmul_stream_tb;

  localparam int DIM = 4;
  localparam int DW  = 32;
  localparam int E   = DIM * DIM;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startIn = 1'b0;
  logic          doneOut, idleOut, readyOut;
  logic [DW-1:0] inData = '0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] outData;
  logic          outValid;
  logic          outReady = 1'b0;
  logic          outLast;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] aM [E];
  logic [DW-1:0] bM [E];
  logic [DW-1:0] cExp [E];

  always #4 clk = ~clk;

  matmul_stream #(.DIM(DIM), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .startIn(startIn), .doneOut(doneOut),
    .idleOut(idleOut), .readyOut(readyOut), .inData(inData),
    .inValid(inValid), .inReady(inReady), .outData(outData),
    .outValid(outValid), .outReady(outReady), .outLast(outLast)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void computeExpected();
    for (int i = 0; i < DIM; i++)
      for (int j = 0; j < DIM; j++) begin
        logic [DW-1:0] s;
        s = '0;
        for (int d = 0; d < DIM; d++) s = s + aM[i*DIM+d] * bM[d*DIM+j];
        cExp[i*DIM+j] = s;
      end
  endfunction

  task automatic runOnce(input int stallPct, input bit pokeStart);
    int k, cycles, idx, guard, storeCycles;
    bit hs, pending;
    logic [DW-1:0] heldD;
    logic heldL;
    computeExpected();
    @(negedge clk); startIn = 1'b1;
    @(negedge clk); startIn = 1'b0;
    chk(readyOut == 1'b1, "R8 ready pulse", DW'(readyOut), 32'd1);
    chk(idleOut == 1'b0, "R2 busy after start", DW'(idleOut), 32'd0);
    k = 0; cycles = 0; guard = 0;
    while (k < 2*E && guard < 5000) begin
      inValid = (stallPct == 0) || (($urandom % 100) >= stallPct);
      inData  = (k < E) ? aM[k] : bM[k-E];
      hs = inValid && inReady;
      @(negedge clk);
      cycles++; guard++;
      if (cycles == 1) chk(readyOut == 1'b0, "R8 ready one cycle", DW'(readyOut), 32'd0);
      if (hs) k++;
    end
    inValid = 1'b0;
    if (stallPct == 0) chk(cycles == 2*E, "R9 load cycles", DW'(cycles), DW'(2*E));
    chk(inReady == 1'b0, "R3 ready drops after load", DW'(inReady), 32'd0);
    idx = 0; guard = 0; pending = 0; storeCycles = 0;
    while (idx < E && guard < 5000) begin
      if (pending) begin
        chk(outValid && outData == heldD && outLast == heldL, "R6 hold", outData, heldD);
        pending = 0;
      end
      outReady = (stallPct == 0) || (($urandom % 100) >= stallPct);
      startIn  = pokeStart && (idx == 2);
      if (outValid) storeCycles++;
      if (outValid && outReady) begin
        chk(outData == cExp[idx], "R4 product", outData, cExp[idx]);
        chk(outLast == (idx == E-1), "R5 last flag", DW'(outLast), DW'(idx == E-1));
        idx++;
      end else if (outValid) begin
        pending = 1; heldD = outData; heldL = outLast;
      end else begin
        chk(outLast == 1'b0, "R5 no last while invalid", DW'(outLast), 32'd0);
      end
      @(negedge clk);
      guard++;
    end
    outReady = 1'b0; startIn = 1'b0;
    if (stallPct == 0) chk(storeCycles == E, "R9 store cycles", DW'(storeCycles), DW'(E));
    chk(doneOut == 1'b1, "R7 done pulse", DW'(doneOut), 32'd1);
    chk(idleOut == 1'b1, "R7 idle with done", DW'(idleOut), 32'd1);
    @(negedge clk);
    chk(doneOut == 1'b0, "R7 done one cycle", DW'(doneOut), 32'd0);
    if (pokeStart) begin
      for (int n = 0; n < 4; n++) begin
        chk(idleOut && !inReady, "R2 start while busy ignored", DW'(idleOut), 32'd1);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(idleOut && !inReady && !outValid && !outLast && !doneOut && !readyOut,
        "R1 reset state", DW'(idleOut), 32'd1);

    // Directed: identity times ramp gives the ramp back.
    for (int e = 0; e < E; e++) begin
      aM[e] = ((e / DIM) == (e % DIM)) ? 32'd1 : 32'd0;
      bM[e] = DW'(e * 3 + 1);
    end
    runOnce(0, 0);

    // Directed: wrap-around with extreme values.
    for (int e = 0; e < E; e++) begin
      aM[e] = (e % 2 == 0) ? 32'h8000_0000 : 32'hFFFF_FFFF;
      bM[e] = (e % 3 == 0) ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
    end
    runOnce(0, 1);

    // Random runs with stalls on both streams.
    for (int r = 0; r < 4; r++) begin
      for (int e = 0; e < E; e++) begin
        aM[e] = $urandom;
        bM[e] = (r == 0) ? ($urandom % 16) : $urandom;
      end
      runOnce(30 + r * 10, r == 1);
    end

    // Reset in the middle of a load.
    @(negedge clk); startIn = 1'b1;
    @(negedge clk); startIn = 1'b0; inValid = 1'b1; inData = 32'h1234_5678;
    repeat (5) @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(idleOut && !inReady && !outValid && !doneOut && !readyOut,
        "R1 reset mid-run", DW'(idleOut), 32'd1);

    // A clean run after the aborted one must still be correct.
    for (int e = 0; e < E; e++) begin
      aM[e] = DW'(e) - 32'd7;
      bM[e] = DW'(E - e);
    end
    runOnce(0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule